// File: doc/BRIEF.md
# Word-Select Clock Ratio Detector

This block finds out, with no configuration pin, how many system clock cycles make up one sample period of an incoming audio frame. The word-select line of a slave-mode serial audio port arrives from another clock domain. The system clock is frequency-locked to it, but its phase is unknown. The block passes word-select through a two-flop synchronizer, counts system clock cycles between successive rising edges, and matches each count against four supported oversampling ratios: 256, 384, 512 and 768 times the sample rate. A count within plus or minus 2 of a nominal value is accepted.

Downstream timing logic reads a 2-bit ratio code, a lock flag and an error flag. Lock is granted only after two consecutive measured periods match the same ratio. A period that matches no ratio drops lock and raises the error flag. In master mode the system clock must be 256 times the sample rate, so the outputs are forced to that ratio. A separate flag marks lock on the 768 ratio, because that ratio is only usable at sample rates up to 55 kHz. System logic uses the flag to enforce that limit.

Top module: `sysclk_ratio_detect`

## Requirements
- R1: While reset is asserted and after its release, before any period is measured, `locked`, `ratio_err` and `low_rate_only` are 0 and `ratio_code` is 2'b00.
- R2: A measured period (system clock cycles from one word-select rising edge to the next) within plus or minus 2 of 256, 384, 512 or 768 is classified as code 2'b00, 2'b01, 2'b10 or 2'b11 respectively; `ratio_code` shows the latest classified code.
- R3: The interval ending at the first rising edge after reset is not measured; `locked` rises only when two consecutive measured periods classify to the same code.
- R4: A measured period outside every window clears `locked` and sets `ratio_err`; the next matching period clears `ratio_err`, and two consecutive matching periods are again needed for lock. `locked` and `ratio_err` are never both 1.
- R5: While locked, a period that classifies to a different code clears `locked` and takes the new code; one further matching period of that code restores lock.
- R6: While `master_mode` is 1, `ratio_code` is 2'b00, `locked` is 1 and `ratio_err` and `low_rate_only` are 0; on return to slave mode, lock must be earned again from two new matching periods.
- R7: `low_rate_only` is 1 exactly when the block is in slave mode and locked on code 2'b11.
- R8: In slave mode the status outputs change only in the cycle after a synchronized word-select rising edge is detected.
- R9: The period counter saturates at its maximum (2047 by default), so a word-select gap longer than that is measured as a non-matching period and raises `ratio_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ws_in | input | 1 | Word-select from the serial audio interface, asynchronous |
| master_mode | input | 1 | 1 selects master mode, which forces the 256 ratio |
| ratio_code | output | 2 | Detected ratio: 00=256, 01=384, 10=512, 11=768 |
| locked | output | 1 | Ratio confirmed by two consecutive matching periods |
| ratio_err | output | 1 | Last measured period matched no ratio |
| low_rate_only | output | 1 | Locked on the 768 ratio; sample rate must stay at or below 55 kHz |

## Verification
On every cycle, the assertions check the following. Lock and error are mutually exclusive. The low-rate flag appears only with lock on code 2'b11. Status is quiet between detected edges. A newly granted lock keeps the code it was earned with. Master mode forces lock and clears the error, and lock is withdrawn at the moment master mode ends. The numeric behaviour can only be shown by the bench scenarios: the exact edges of each tolerance window, the two-period lock rule, relock after a ratio change or error, and saturation on a long gap. For these, the bench drives word-select with chosen periods and compares the outputs against a period model of its own.

// File: rtl/ratio_det_pkg.sv
package ratio_det_pkg;

  localparam int NUM_RATIOS = 4;
  localparam int RATIO_UNIT = 128;

  typedef enum logic [1:0] {
    RATIO_256 = 2'b00,
    RATIO_384 = 2'b01,
    RATIO_512 = 2'b10,
    RATIO_768 = 2'b11
  } ratio_e;

  // Nominal cycles per word-select period for each code, as multiples of 128.
  function automatic int nominal_of(input int idx);
    case (idx)
      0:       nominal_of = 2 * RATIO_UNIT;
      1:       nominal_of = 3 * RATIO_UNIT;
      2:       nominal_of = 4 * RATIO_UNIT;
      default: nominal_of = 6 * RATIO_UNIT;
    endcase
  endfunction

endpackage

// File: rtl/ws_sync_edge.sv
module ws_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ws_async,
  output logic ws_rise
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   hist_q;
  logic                   hist_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], ws_async};
    hist_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
    end
  end

  assign ws_rise = sync_q[SYNC_STAGES-1] & ~hist_q;

endmodule

// File: rtl/ws_period_counter.sv
module ws_period_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_seen,
  output logic             meas_valid,
  output logic [CNT_W-1:0] meas_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (edge_seen) begin
      cnt_d   = CNT_W'(1);
      armed_d = 1'b1;
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign meas_valid = edge_seen & armed_q;
  assign meas_count = cnt_q;

endmodule

// File: rtl/ratio_window_match.sv
module ratio_window_match
  import ratio_det_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int TOL   = 2
) (
  input  logic [CNT_W-1:0] meas_count,
  output logic             any_hit,
  output ratio_e           hit_code
);

  logic [NUM_RATIOS-1:0] hit;

  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_win
    localparam int NOM = nominal_of(i);
    localparam logic [CNT_W-1:0] LO = CNT_W'(NOM - TOL);
    localparam logic [CNT_W-1:0] HI = CNT_W'(NOM + TOL);
    assign hit[i] = (meas_count >= LO) && (meas_count <= HI);
  end

  always_comb begin
    hit_code = RATIO_256;
    for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
      if (hit[i]) hit_code = ratio_e'(i);
    end
  end

  assign any_hit = |hit;

endmodule

// File: rtl/sysclk_ratio_detect.sv
module sysclk_ratio_detect
  import ratio_det_pkg::*;
#(
  parameter int TOL         = 2,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(nominal_of(NUM_RATIOS - 1) + TOL + 1) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ws_in,
  input  logic       master_mode,
  output logic [1:0] ratio_code,
  output logic       locked,
  output logic       ratio_err,
  output logic       low_rate_only
);

  logic             ws_rise;
  logic             meas_valid;
  logic [CNT_W-1:0] meas_count;
  logic             any_hit;
  ratio_e           hit_code;

  ws_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .ws_async (ws_in),
    .ws_rise  (ws_rise)
  );

  ws_period_counter #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_seen  (ws_rise),
    .meas_valid (meas_valid),
    .meas_count (meas_count)
  );

  ratio_window_match #(.CNT_W(CNT_W), .TOL(TOL)) u_match (
    .meas_count (meas_count),
    .any_hit    (any_hit),
    .hit_code   (hit_code)
  );

  // Lock sequencer state
  ratio_e prev_q, prev_d;
  logic   have_q, have_d;
  logic   lock_q, lock_d;
  logic   err_q,  err_d;

  always_comb begin
    prev_d = prev_q;
    have_d = have_q;
    lock_d = lock_q;
    err_d  = err_q;
    if (master_mode) begin
      prev_d = RATIO_256;
      have_d = 1'b0;
      lock_d = 1'b0;
      err_d  = 1'b0;
    end else if (meas_valid) begin
      if (!any_hit) begin
        have_d = 1'b0;
        lock_d = 1'b0;
        err_d  = 1'b1;
      end else begin
        lock_d = have_q && (hit_code == prev_q);
        prev_d = hit_code;
        have_d = 1'b1;
        err_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= RATIO_256;
      have_q <= 1'b0;
      lock_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      have_q <= have_d;
      lock_q <= lock_d;
      err_q  <= err_d;
    end
  end

  assign ratio_code    = master_mode ? RATIO_256 : prev_q;
  assign locked        = master_mode | lock_q;
  assign ratio_err     = ~master_mode & err_q;
  assign low_rate_only = ~master_mode & lock_q & (prev_q == RATIO_768);

endmodule

// File: rtl/ratio_detect_checker.sv
module ratio_detect_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       master_mode,
  input logic       ws_rise,
  input logic [1:0] ratio_code,
  input logic       locked,
  input logic       ratio_err,
  input logic       low_rate_only
);

  assert_lock_err_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked && ratio_err));

  assert_low_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    low_rate_only |-> (locked && ratio_code == 2'b11 && !master_mode));

  assert_master_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode |-> (locked && !ratio_err && !low_rate_only && ratio_code == 2'b00));

  assert_master_exit_unlock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(master_mode) |-> !locked);

  assert_lock_keeps_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && !$past(master_mode) && $rose(locked)) |-> $stable(ratio_code));

  assert_quiet_between_edges_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && !$past(master_mode) && !$past(ws_rise))
      |-> ($stable(locked) && $stable(ratio_err) && $stable(ratio_code)));

endmodule

bind sysclk_ratio_detect ratio_detect_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .master_mode   (master_mode),
  .ws_rise       (ws_rise),
  .ratio_code    (ratio_code),
  .locked        (locked),
  .ratio_err     (ratio_err),
  .low_rate_only (low_rate_only)
);

// File: tb/sysclk_ratio_detect_test.sv
module sysclk_ratio_detect_test;

  localparam int CNT_MAX = 2047;

  logic       clk;
  logic       rst_n;
  logic       ws_in;
  logic       master_mode;
  logic [1:0] ratio_code;
  logic       locked;
  logic       ratio_err;
  logic       low_rate_only;

  int vectors    = 0;
  int miscompares = 0;
  int cyc        = 0;
  bit done       = 0;

  // bench model of the lock rules
  bit       m_seen, m_have, m_lock, m_err;
  int       m_last;
  logic [1:0] m_prev;

  sysclk_ratio_detect uut (
    .clk(clk), .rst_n(rst_n), .ws_in(ws_in), .master_mode(master_mode),
    .ratio_code(ratio_code), .locked(locked), .ratio_err(ratio_err),
    .low_rate_only(low_rate_only)
  );

  initial clk = 0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit in_window(int m, int nom);
    return (m >= nom - 2) && (m <= nom + 2);
  endfunction

  function automatic int classify(int m);  // returns -1 for no match
    if (in_window(m, 256)) return 0;
    if (in_window(m, 384)) return 1;
    if (in_window(m, 512)) return 2;
    if (in_window(m, 768)) return 3;
    return -1;
  endfunction

  task automatic model_clear();
    m_have = 0; m_lock = 0; m_err = 0; m_prev = 2'b00;
  endtask

  task automatic model_rise();
    int meas, c;
    if (m_seen && !master_mode) begin
      meas = cyc - m_last;
      if (meas > CNT_MAX) meas = CNT_MAX;
      c = classify(meas);
      if (c < 0) begin
        m_have = 0; m_lock = 0; m_err = 1;
      end else begin
        m_lock = m_have && (2'(c) == m_prev);
        m_prev = 2'(c);
        m_have = 1; m_err = 0;
      end
    end
    m_seen = 1;
    m_last = cyc;
  endtask

  task automatic one_period(int p);
    ws_in = 1'b1;
    model_rise();
    repeat (p / 2) @(negedge clk);
    ws_in = 1'b0;
    repeat (p - p / 2) @(negedge clk);
  endtask

  task automatic periods(int p, int n);
    for (int i = 0; i < n; i++) one_period(p);
  endtask

  task automatic check(string req);
    logic [1:0] e_code;
    logic e_lock, e_err, e_low;
    if (master_mode) begin
      e_code = 2'b00; e_lock = 1; e_err = 0; e_low = 0;
    end else begin
      e_code = m_prev; e_lock = m_lock; e_err = m_err;
      e_low  = m_lock && (m_prev == 2'b11);
    end
    vectors++;
    if (ratio_code !== e_code || locked !== e_lock || ratio_err !== e_err ||
        low_rate_only !== e_low) begin
      miscompares++;
      $display("FAIL %s: code/lock/err/low actual %b/%b/%b/%b expected %b/%b/%b/%b",
               req, ratio_code, locked, ratio_err, low_rate_only,
               e_code, e_lock, e_err, e_low);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int base, off, n, p;
    void'($urandom(32'd1361));
    rst_n = 0; ws_in = 0; master_mode = 0;
    m_seen = 0; m_last = 0; model_clear();
    repeat (4) @(negedge clk);
    check("R1 in reset");
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 after release");

    // R3: first rise not measured, one period not yet locked
    periods(256, 2);
    check("R3 one period, no lock");
    periods(256, 1);
    check("R3 lock on 256");

    // R2 windows: edges of tolerance
    periods(386, 3);
    check("R2 384+2 lock code 01");
    periods(510, 3);
    check("R2 512-2 lock code 10");
    periods(768, 3);
    check("R7 768 lock raises low-rate flag");

    // R4 out-of-window just past the tolerance
    periods(771, 1);
    check("R4 771 raises error");
    periods(253, 1);
    check("R4 253 still error");
    periods(254, 1);
    check("R4 254 clears error, no lock");
    periods(258, 1);
    check("R4 relock after error");

    // R5 change of ratio while locked
    periods(512, 1);
    check("R5 new ratio drops lock");
    periods(512, 1);
    check("R5 relock on new ratio");

    // R6 master mode
    repeat (8) @(negedge clk);
    master_mode = 1; model_clear();
    repeat (3) @(negedge clk);
    check("R6 master forced outputs");
    repeat (20) @(negedge clk);
    master_mode = 0;
    @(negedge clk);
    check("R6 master exit unlocked");
    periods(384, 2);
    check("R6 first slave period after master");
    periods(384, 1);
    check("R6 relock after master");

    // R9 saturation on long gap
    ws_in = 1; model_rise();
    repeat (1500) @(negedge clk);
    ws_in = 0;
    repeat (1500) @(negedge clk);
    periods(384, 1);
    check("R9 saturated gap is error");
    periods(384, 2);
    check("R9 relock after gap");

    // random mix with R8 spot checks
    for (int k = 0; k < 30; k++) begin
      base = int'($urandom % 4);
      off  = int'($urandom % 7) - 3;
      case (base)
        0: p = 256; 1: p = 384; 2: p = 512; default: p = 768;
      endcase
      p = p + off;
      if (($urandom % 8) == 0) p = 200 + int'($urandom % 700);
      n = 1 + int'($urandom % 3);
      periods(p, n);
      check("R2 random period");
      repeat (40) @(negedge clk);
      check("R8 no change between edges");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule